// File: doc/BRIEF.md
# Two-Wire Bus Clear Sequencer

This block frees a two-wire serial bus when a target has been left holding the data line low. That can happen when the controller is reset partway through a transfer. The block drives the clock and data lines only through open-drain pull enables: a 1 on an enable pulls the line low, and a 0 lets the pull-up raise it. It plays a fixed pattern on the lines. First comes a start condition. Then nine clock pulses run with data left floating, which gives a stranded target room to finish its byte and its acknowledge slot. A repeated start follows, which resets the target's protocol logic, and finally a stop condition hands the bus back in the idle state.

The pattern runs once by itself in the first cycle after reset is released. After that it runs again each time the trigger input is pulsed while the block is idle. The pace is set by a quarter-period divider of the system clock. Data edges that are not part of a start or stop fall in the middle of a clock-low phase. The pattern is always played in full, whatever levels the lines show. While clock and data are both released just before the repeated start, the block samples them and keeps the result, so a host can tell whether the data line came free.

Top module: `busclr_seq`

## Requirements
- R1: While `rst` is high, `scl_pull`, `sda_pull`, `busy`, `done` and `bus_ok` are all 0. The first cycle after `rst` falls shows `busy` low. The next cycle shows `busy` high, because a run starts by itself with no trigger.
- R2: The line outputs are open-drain pull enables, where 1 means pull the line low. Whenever `busy` is 0, both enables are 0.
- R3: A run opens with both lines released for 2*QUARTER_CYC cycles. Then `sda_pull` rises while `scl_pull` stays 0, which is the start condition, and that state holds for 2*QUARTER_CYC cycles.
- R4: After the start, exactly NUM_CLOCKS (default 9) clock pulses follow. `sda_pull` is 0 throughout every clock-high phase. Data is let go QUARTER_CYC cycles into the first low phase.
- R5: After the last of those pulses, SCL goes low for one phase and is then released with SDA released. After 2*QUARTER_CYC cycles, `sda_pull` rises while SCL stays released, which is the repeated start.
- R6: SCL is then pulled low with SDA still pulled, and released again. `sda_pull` then falls while SCL is released, which is the stop. Both lines stay released for 2*QUARTER_CYC cycles before the run ends.
- R7: `sda_pull` never changes in the same cycle as `scl_pull`. Every SCL-low phase lasts exactly 2*QUARTER_CYC cycles.
- R8: `busy` stays high for exactly (4*NUM_CLOCKS+16)*QUARTER_CYC cycles, which is 52 quarters by default. `done` is high for one cycle, in the first cycle with `busy` low.
- R9: A one-cycle `kick` while idle raises `busy` in the following cycle. A `kick` while `busy` is high is ignored and starts no second run.
- R10: The full pattern is produced whatever `scl_in` and `sda_in` show, including when a target holds SDA low for part of the run or for all of it.
- R11: `bus_ok` takes the value (`scl_in` AND `sda_in`) sampled in the last cycle before the repeated start. It holds that value until the next run samples again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Request a recovery run (acted on only when idle) |
| scl_in | input | 1 | Sampled level of the clock line |
| sda_in | input | 1 | Sampled level of the data line |
| scl_pull | output | 1 | Pull clock line low when 1, release when 0 |
| sda_pull | output | 1 | Pull data line low when 1, release when 0 |
| busy | output | 1 | A recovery run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| bus_ok | output | 1 | Both lines were seen high just before the repeated start |

## Verification
The hardest case is a target that still holds SDA low when the run begins. That target hides the opening start on the wire, keeps holding through some of the clocks, and lets go partway. The bench models the wired-AND data line, with a target hold that drops after a programmed number of SCL falling edges, and it also runs a target that never lets go. In both cases it checks that the driven pattern is unchanged and that the status bit follows the line level seen just before the repeated start. Triggers arriving in the middle of a run, and a reset in the middle of a run, are also exercised.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_START,
        ST_LO1,
        ST_LO2,
        ST_HI,
        ST_RS_LO,
        ST_RS_SETUP,
        ST_RS_HOLD,
        ST_P_LO,
        ST_P_SETUP,
        ST_P_HOLD
    } seq_state_e;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } line_drive_t;

    // Quarters per run: idle lead-in and start (4), four per clock, tail (12)
    function automatic int run_quarters(input int n_clocks);
        return 4 + 4 * n_clocks + 12;
    endfunction

    // Remaining-quarter load value on entry: low-phase halves last one quarter
    function automatic logic state_last_q(input seq_state_e s);
        return (s == ST_LO1 || s == ST_LO2) ? 1'b0 : 1'b1;
    endfunction

    function automatic line_drive_t state_drive(input seq_state_e s, input logic first_clk);
        line_drive_t d;
        d = '{scl_pull: 1'b0, sda_pull: 1'b0};
        case (s)
            ST_START:   d.sda_pull = 1'b1;
            ST_LO1:     begin d.scl_pull = 1'b1; d.sda_pull = first_clk; end
            ST_LO2:     d.scl_pull = 1'b1;
            ST_RS_LO:   d.scl_pull = 1'b1;
            ST_RS_HOLD: d.sda_pull = 1'b1;
            ST_P_LO:    begin d.scl_pull = 1'b1; d.sda_pull = 1'b1; end
            ST_P_SETUP: d.sda_pull = 1'b1;
            default:    d = '{scl_pull: 1'b0, sda_pull: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/busclr_tick.sv
module busclr_tick #(
    parameter int QUARTER_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(QUARTER_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/busclr_fsm.sv
module busclr_fsm
    import busclr_pkg::*;
#(
    parameter int NUM_CLOCKS = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kick,
    input  logic       tick,
    output seq_state_e state,
    output logic       first_clk,
    output logic       busy,
    output logic       done,
    output logic       sample_now
);
    localparam int IW = (NUM_CLOCKS > 1) ? $clog2(NUM_CLOCKS) : 1;

    logic          armed;
    logic          qleft;
    logic [IW-1:0] clk_idx;
    seq_state_e    nxt;

    always_comb begin
        case (state)
            ST_PRE:      nxt = ST_START;
            ST_START:    nxt = ST_LO1;
            ST_LO1:      nxt = ST_LO2;
            ST_LO2:      nxt = ST_HI;
            ST_HI:       nxt = (clk_idx == IW'(NUM_CLOCKS - 1)) ? ST_RS_LO : ST_LO1;
            ST_RS_LO:    nxt = ST_RS_SETUP;
            ST_RS_SETUP: nxt = ST_RS_HOLD;
            ST_RS_HOLD:  nxt = ST_P_LO;
            ST_P_LO:     nxt = ST_P_SETUP;
            ST_P_SETUP:  nxt = ST_P_HOLD;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            armed   <= 1'b1;
            qleft   <= 1'b0;
            clk_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (armed || kick) begin
                    state   <= ST_PRE;
                    qleft   <= state_last_q(ST_PRE);
                    armed   <= 1'b0;
                    clk_idx <= '0;
                end
            end else if (tick) begin
                if (qleft) begin
                    qleft <= 1'b0;
                end else begin
                    state <= nxt;
                    qleft <= state_last_q(nxt);
                    if (state == ST_HI) clk_idx <= clk_idx + 1'b1;
                    if (state == ST_P_HOLD) done <= 1'b1;
                end
            end
        end
    end

    assign busy       = (state != ST_IDLE);
    assign first_clk  = (clk_idx == '0);
    assign sample_now = tick && !qleft && (state == ST_RS_SETUP);
endmodule

// File: rtl/busclr_seq.sv
module busclr_seq
    import busclr_pkg::*;
#(
    parameter int QUARTER_CYC = 250,
    parameter int NUM_CLOCKS  = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic done,
    output logic bus_ok
);
    seq_state_e  state;
    logic        tick;
    logic        first_clk;
    logic        sample_now;
    line_drive_t drv;

    busclr_tick #(.QUARTER_CYC(QUARTER_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .tick (tick)
    );

    busclr_fsm #(.NUM_CLOCKS(NUM_CLOCKS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .kick       (kick),
        .tick       (tick),
        .state      (state),
        .first_clk  (first_clk),
        .busy       (busy),
        .done       (done),
        .sample_now (sample_now)
    );

    assign drv      = state_drive(state, first_clk);
    assign scl_pull = drv.scl_pull;
    assign sda_pull = drv.sda_pull;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ok <= 1'b0;
        end else if (sample_now) begin
            bus_ok <= scl_in && sda_in;
        end
    end
endmodule

// File: rtl/busclr_seq_chk.sv
module busclr_seq_chk #(
    parameter int NUM_CLOCKS = 9
) (
    input logic clk,
    input logic rst,
    input logic kick,
    input logic scl_pull,
    input logic sda_pull,
    input logic busy,
    input logic done
);
    logic       scl_pull_q;
    logic [7:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pull_q <= 1'b0;
            rise_cnt   <= '0;
        end else begin
            scl_pull_q <= scl_pull;
            if (done) rise_cnt <= '0;
            else if (scl_pull_q && !scl_pull) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_pull && !sda_pull)); // R2

    AST_RUN_OPENS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!scl_pull && !sda_pull)); // R3

    AST_SDA_APART_FROM_SCL: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_pull) |-> $stable(sda_pull)); // R7

    AST_CLOCK_TOTAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (rise_cnt == 8'(NUM_CLOCKS + 2))); // R4

    AST_CLOCK_BOUND: assert property (@(posedge clk) disable iff (rst)
        rise_cnt <= 8'(NUM_CLOCKS + 2)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R8

    AST_KICK_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && kick) |=> (busy || done)); // R9
endmodule

bind busclr_seq busclr_seq_chk #(.NUM_CLOCKS(NUM_CLOCKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .kick     (kick),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .done     (done)
);

// File: tb/busclr_seq_bench.sv
module busclr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int NCLK       = 9;
    localparam int RUN_CYC    = (4 * NCLK + 16) * Q;

    localparam int EV_S    = 1;
    localparam int EV_H    = 2;
    localparam int EV_P    = 3;
    localparam int EV_DONE = 4;
    localparam int EV_BAD  = 5;

    typedef struct {
        int    ev;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst;
    logic kick;
    logic scl_in, sda_in;
    logic scl_pull, sda_pull, busy, done, bus_ok;

    int   total = 0;
    int   bad   = 0;
    bit   ended = 0;
    exp_t exp_q[$];

    // target model: holds SDA low until hold_for SCL falls after hold_mark
    bit   hold_on  = 0;
    int   hold_for = 0;
    int   hold_mark = 0;
    int   falls = 0;
    logic hold;

    int   cyc = 0;
    int   ndone = 0;
    int   lo_start = -1;
    int   busy_start = -1;
    logic prev_scl = 1'b0, prev_sda = 1'b0, prev_busy = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign hold   = hold_on && ((hold_for < 0) || ((falls - hold_mark) < hold_for));
    assign scl_in = !scl_pull;
    assign sda_in = !sda_pull && !hold;

    busclr_seq #(.QUARTER_CYC(Q), .NUM_CLOCKS(NCLK)) u_busclr_seq (
        .clk      (clk),
        .rst      (rst),
        .kick     (kick),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .busy     (busy),
        .done     (done),
        .bus_ok   (bus_ok)
    );

    task automatic note(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic match(input int ev);
        exp_t e;
        if (exp_q.size() == 0) begin
            note(1'b0, "R10 unexpected event", ev, 0);
        end else begin
            e = exp_q.pop_front();
            note(e.ev == ev, e.req, ev, e.ev);
        end
    endtask

    // driver: expected line events of one full run
    task automatic expect_run();
        exp_q.push_back('{EV_S, "R3 start"});
        for (int i = 0; i < NCLK; i++) exp_q.push_back('{EV_H, "R4 clock pulse"});
        exp_q.push_back('{EV_H, "R5 scl high before Sr"});
        exp_q.push_back('{EV_S, "R5 repeated start"});
        exp_q.push_back('{EV_H, "R6 scl high before stop"});
        exp_q.push_back('{EV_P, "R6 stop"});
        exp_q.push_back('{EV_DONE, "R8 done"});
    endtask

    task automatic wait_done(input int n);
        while (ndone < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        bit scl_chg, sda_chg;
        cyc++;
        if (rst) begin
            lo_start   = -1;
            busy_start = -1;
        end else begin
            scl_chg = (scl_pull != prev_scl);
            sda_chg = (sda_pull != prev_sda);
            if (scl_chg && sda_chg) match(EV_BAD);
            else if (sda_chg && !scl_pull) match(sda_pull ? EV_S : EV_P);
            else if (scl_chg && !scl_pull) match(EV_H);
            if (scl_chg && scl_pull) begin
                lo_start = cyc;
                falls++;
            end
            if (scl_chg && !scl_pull && lo_start >= 0)
                note(cyc - lo_start == 2 * Q, "R7 low phase length", cyc - lo_start, 2 * Q);
            if (busy && !prev_busy) busy_start = cyc;
            if (!busy && prev_busy && busy_start >= 0)
                note(cyc - busy_start == RUN_CYC, "R8 busy length", cyc - busy_start, RUN_CYC);
            if (done) begin
                ndone++;
                match(EV_DONE);
                note(!busy, "R8 busy low with done", busy, 0);
            end
        end
        prev_scl  = scl_pull;
        prev_sda  = sda_pull;
        prev_busy = busy;
    end

    initial begin
        repeat (150000) @(posedge clk);
        note(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int nd;
        rst  = 1'b1;
        kick = 1'b0;
        repeat (4) @(negedge clk);
        note(!scl_pull && !sda_pull, "R1 pulls in reset", {scl_pull, sda_pull}, 0);
        note(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
        note(!bus_ok, "R1 bus_ok in reset", bus_ok, 0);

        // automatic run after reset
        expect_run();
        @(negedge clk) rst = 1'b0;
        #1 note(!busy, "R1 busy before first edge", busy, 0);
        @(negedge clk);
        note(busy, "R1 auto start", busy, 1);
        wait_done(1);
        note(bus_ok, "R11 clean bus", bus_ok, 1);
        note(exp_q.size() == 0, "R10 full pattern", exp_q.size(), 0);
        note(!scl_pull && !sda_pull, "R2 released after run", {scl_pull, sda_pull}, 0);

        // idle kick, with kicks during the run ignored
        expect_run();
        pulse_kick();
        note(busy, "R9 kick starts run", busy, 1);
        repeat (40) @(negedge clk);
        pulse_kick();
        repeat (50) @(negedge clk);
        pulse_kick();
        pulse_kick();
        wait_done(2);
        nd = ndone;
        repeat (2 * RUN_CYC) @(negedge clk);
        note(!busy, "R9 no second run", busy, 0);
        note(ndone == nd, "R9 single done", ndone, nd);

        // target holding SDA, lets go after three SCL falls
        hold_mark = falls;
        hold_for  = 3;
        hold_on   = 1;
        expect_run();
        pulse_kick();
        wait_done(3);
        note(bus_ok, "R11 released target", bus_ok, 1);
        note(!hold, "R10 target let go", hold, 0);
        note(exp_q.size() == 0, "R10 full pattern with hold", exp_q.size(), 0);

        // target never lets go
        hold_for = -1;
        expect_run();
        pulse_kick();
        wait_done(4);
        note(!bus_ok, "R11 stuck target", bus_ok, 0);
        note(exp_q.size() == 0, "R10 full pattern stuck", exp_q.size(), 0);
        hold_on = 0;

        // clean run restores status
        expect_run();
        pulse_kick();
        wait_done(5);
        note(bus_ok, "R11 status restored", bus_ok, 1);

        // reset in the middle of a run, then automatic run again
        expect_run();
        pulse_kick();
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        note(!scl_pull && !sda_pull && !busy, "R1 reset mid run", {scl_pull, sda_pull, busy}, 0);
        note(!bus_ok, "R1 status cleared", bus_ok, 0);
        exp_q.delete();
        expect_run();
        nd = ndone;
        @(negedge clk) rst = 1'b0;
        wait_done(nd + 1);
        note(exp_q.size() == 0, "R10 pattern after reset", exp_q.size(), 0);
        note(bus_ok, "R11 after reset run", bus_ok, 1);

        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule